// File: doc/BRIEF.md
# Standby Entry and Exit Sequencer

This controller moves a scan-testable sequential design into a low-leakage standby condition and later brings it back. When standby is requested, the controller first switches every output control-point multiplexer to its preset hold value. Only after that does it raise the bias-enable output, which tells the analog bias network to reverse-bias the combinational logic. While bias is on, the primary outputs keep their hold values and the state registers are not relied on.

Wake-up runs in a different order. The controller first drops the bias enable. It waits a programmable settle time, and then streams a chosen restart state into the state registers through the scan chain, one bit per handshake with an external scan engine. Only when the last bit has been accepted does it return the control points to functional logic. A matching settle delay also follows the bias rise during entry. A wake request that arrives before entry has finished is remembered, and exit begins as soon as entry has settled.

Top module: `stby_seq_ctrl`

## Requirements
- R1: After reset the following values hold: `cp_sel` is all zeros, `standby` is 0, `scan_en` is 0, `shift_valid` is 0, `ready` is 1 and `busy` is 0.
- R2: A `sleep_req` sampled high in normal operation sets every `cp_sel` bit to 1 on the next clock edge. `standby` rises exactly one cycle later. Whenever `standby` is 1, all `cp_sel` bits are 1.
- R3: After `standby` rises, `busy` stays 1 for `settle_cycles`+1 cycles, and then the block rests with `standby`=1 and `busy`=0. After `standby` falls, `shift_valid` rises only after `settle_cycles`+1 cycles with `standby`=0.
- R4: A `wake_req` sampled in the resting state first clears `standby` while `cp_sel` stays all ones. `scan_en` and `shift_valid` are never 1 while `standby` is 1.
- R5: During reload, `scan_en` and `shift_valid` are 1 and `scan_si` carries `restart_state`, bit 0 first, one bit per cycle in which `shift_valid` and `shift_ready` are both 1, for STATE_W transfers. `scan_si` holds its value while `shift_ready` is 0.
- R6: In the cycle after the last transfer, `cp_sel` returns to all zeros, `ready` becomes 1, and `scan_en` and `shift_valid` become 0.
- R7: A `wake_req` seen while entry is still in progress (`busy`=1, `standby` not yet resting) is remembered. `standby` then stays 1 for exactly `settle_cycles`+1 cycles and falls without the block ever resting.
- R8: `wake_req` has no effect in normal operation, and `sleep_req` has no effect outside normal operation.
- R9: `ready` is 1 only in normal operation, with all `cp_sel` bits 0 and `standby` at 0. `busy` is 1 during the entry steps, the exit steps and the reload, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Request to enter standby |
| wake_req | input | 1 | Request to leave standby |
| settle_cycles | input | SETTLE_W | Settle delay after each bias change |
| restart_state | input | STATE_W | State to load through the scan chain on exit |
| shift_ready | input | 1 | Scan engine accepts the current bit |
| cp_sel | output | NUM_CP | Control-point selects, 1 = hold value |
| standby | output | 1 | Bias enable, active high |
| scan_en | output | 1 | Scan shift mode enable |
| shift_valid | output | 1 | A scan bit is offered on scan_si |
| scan_si | output | 1 | Serial scan data |
| busy | output | 1 | An entry or exit step is in progress |
| ready | output | 1 | Normal operation, control points released |

## Verification
The hardest case to reach from the ports is a wake request that lands while entry is still running, before the resting state exists. The stimulus gets there by pulsing `wake_req` on the cycle right after `sleep_req`. It does this once with a zero settle time, where the bias-on window is a single cycle, and once with a longer one. In both runs it checks that the block never rests and that bias drops after exactly the settle window. The reload runs both with `shift_ready` held high and with it toggling, so that the hold of `scan_si` under back-pressure is exercised.

// File: rtl/stby_pkg.sv
package stby_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_HOLD,
        ST_BIAS_SETTLE,
        ST_REST,
        ST_UNBIAS,
        ST_RELOAD
    } stby_state_t;

endpackage

// File: rtl/stby_settle_timer.sv
module stby_settle_timer #(
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [SETTLE_W-1:0] load_val,
    output logic                expired
);

    typedef struct packed {
        logic [SETTLE_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.cnt = load_val;
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign expired = (tmr_q.cnt == '0);

endmodule

// File: rtl/stby_scan_loader.sv
module stby_scan_loader #(
    parameter int STATE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [STATE_W-1:0] data,
    input  logic               active,
    input  logic               shift_ready,
    output logic               scan_si,
    output logic               last_xfer
);

    localparam int CNT_W = $clog2(STATE_W + 1);

    typedef struct packed {
        logic [STATE_W-1:0] shreg;
        logic [CNT_W-1:0]   left;
    } ldr_t;

    ldr_t ldr_d, ldr_q;
    logic xfer;

    assign xfer = active && shift_ready && (ldr_q.left != '0);

    always_comb begin
        ldr_d = ldr_q;
        if (start) begin
            ldr_d.shreg = data;
            ldr_d.left  = CNT_W'(STATE_W);
        end else if (xfer) begin
            ldr_d.shreg = ldr_q.shreg >> 1;
            ldr_d.left  = ldr_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ldr_q <= '0;
        else        ldr_q <= ldr_d;
    end

    assign scan_si   = ldr_q.shreg[0];
    assign last_xfer = xfer && (ldr_q.left == CNT_W'(1));

endmodule

// File: rtl/stby_seq_ctrl.sv
module stby_seq_ctrl
    import stby_pkg::*;
#(
    parameter int NUM_CP   = 4,
    parameter int STATE_W  = 8,
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sleep_req,
    input  logic                wake_req,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic [STATE_W-1:0]  restart_state,
    input  logic                shift_ready,
    output logic [NUM_CP-1:0]   cp_sel,
    output logic                standby,
    output logic                scan_en,
    output logic                shift_valid,
    output logic                scan_si,
    output logic                busy,
    output logic                ready
);

    typedef struct packed {
        stby_state_t st;
        logic        wake_pend;
    } seq_t;

    seq_t seq_d, seq_q;
    logic tmr_load, tmr_expired;
    logic ldr_start, ldr_last;
    logic hold_all;

    stby_settle_timer #(.SETTLE_W(SETTLE_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (settle_cycles),
        .expired  (tmr_expired)
    );

    stby_scan_loader #(.STATE_W(STATE_W)) u_loader (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (ldr_start),
        .data        (restart_state),
        .active      (seq_q.st == ST_RELOAD),
        .shift_ready (shift_ready),
        .scan_si     (scan_si),
        .last_xfer   (ldr_last)
    );

    always_comb begin
        seq_d     = seq_q;
        tmr_load  = 1'b0;
        ldr_start = 1'b0;
        unique case (seq_q.st)
            ST_RUN: begin
                seq_d.wake_pend = 1'b0;
                if (sleep_req) seq_d.st = ST_HOLD;
            end
            ST_HOLD: begin
                seq_d.st = ST_BIAS_SETTLE;
                tmr_load = 1'b1;
                if (wake_req) seq_d.wake_pend = 1'b1;
            end
            ST_BIAS_SETTLE: begin
                if (wake_req) seq_d.wake_pend = 1'b1;
                if (tmr_expired) begin
                    if (seq_q.wake_pend || wake_req) begin
                        seq_d.st        = ST_UNBIAS;
                        seq_d.wake_pend = 1'b0;
                        tmr_load        = 1'b1;
                        ldr_start       = 1'b1;
                    end else begin
                        seq_d.st = ST_REST;
                    end
                end
            end
            ST_REST: begin
                if (wake_req) begin
                    seq_d.st  = ST_UNBIAS;
                    tmr_load  = 1'b1;
                    ldr_start = 1'b1;
                end
            end
            ST_UNBIAS: begin
                if (tmr_expired) seq_d.st = ST_RELOAD;
            end
            ST_RELOAD: begin
                if (ldr_last) seq_d.st = ST_RUN;
            end
            default: seq_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: ST_RUN, wake_pend: 1'b0};
        else        seq_q <= seq_d;
    end

    assign hold_all = (seq_q.st != ST_RUN);

    for (genvar g = 0; g < NUM_CP; g++) begin : g_cp
        assign cp_sel[g] = hold_all;
    end

    assign standby     = (seq_q.st == ST_BIAS_SETTLE) || (seq_q.st == ST_REST);
    assign scan_en     = (seq_q.st == ST_RELOAD);
    assign shift_valid = (seq_q.st == ST_RELOAD);
    assign busy        = (seq_q.st != ST_RUN) && (seq_q.st != ST_REST);
    assign ready       = (seq_q.st == ST_RUN);

endmodule

// File: rtl/stby_seq_ctrl_chk.sv
module stby_seq_ctrl_chk #(
    parameter int NUM_CP   = 4,
    parameter int STATE_W  = 8,
    parameter int SETTLE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              shift_ready,
    input logic [NUM_CP-1:0] cp_sel,
    input logic              standby,
    input logic              scan_en,
    input logic              shift_valid,
    input logic              scan_si,
    input logic              busy,
    input logic              ready
);

    AST_HOLD_BEFORE_BIAS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(standby) |-> $past(&cp_sel)); // R2

    AST_BIAS_HOLDS_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> (&cp_sel)); // R2

    AST_BIAS_DROP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(standby) |-> ((&cp_sel) && !scan_en)); // R4

    AST_NO_SHIFT_UNDER_BIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_valid || scan_en) |-> !standby); // R4

    AST_SI_HELD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_valid && !shift_ready) |=> (shift_valid && $stable(scan_si))); // R5

    AST_RELEASE_AFTER_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cp_sel[0]) |-> $past(shift_valid && shift_ready)); // R6

    AST_READY_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> ((cp_sel == '0) && !standby && !shift_valid && !busy)); // R9

endmodule

bind stby_seq_ctrl stby_seq_ctrl_chk #(
    .NUM_CP   (NUM_CP),
    .STATE_W  (STATE_W),
    .SETTLE_W (SETTLE_W)
) u_chk (.*);

// File: tb/stby_seq_ctrl_test.sv
module stby_seq_ctrl_test;

    localparam int NUM_CP   = 4;
    localparam int STATE_W  = 8;
    localparam int SETTLE_W = 8;
    localparam int NVEC     = 4;

    // vector: {settle[7:0], restart[7:0], early_wake, stall}
    localparam logic [17:0] VEC [NVEC] = '{
        {8'd0, 8'hA5, 1'b0, 1'b0},
        {8'd3, 8'h3C, 1'b0, 1'b1},
        {8'd5, 8'h81, 1'b1, 1'b0},
        {8'd0, 8'h5A, 1'b1, 1'b1}
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                sleep_req = 1'b0;
    logic                wake_req = 1'b0;
    logic [SETTLE_W-1:0] settle_cycles = '0;
    logic [STATE_W-1:0]  restart_state = '0;
    logic                shift_ready = 1'b0;
    logic [NUM_CP-1:0]   cp_sel;
    logic                standby, scan_en, shift_valid, scan_si, busy, ready;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    stby_seq_ctrl #(.NUM_CP(NUM_CP), .STATE_W(STATE_W), .SETTLE_W(SETTLE_W)) uut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
        .settle_cycles(settle_cycles), .restart_state(restart_state),
        .shift_ready(shift_ready), .cp_sel(cp_sel), .standby(standby),
        .scan_en(scan_en), .shift_valid(shift_valid), .scan_si(scan_si),
        .busy(busy), .ready(ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int outs();
        return {cp_sel, standby, scan_en, shift_valid, busy, ready};
    endfunction

    localparam int RESET_OUTS = {{NUM_CP{1'b0}}, 5'b00001};

    task automatic scenario(input logic [7:0] st, input logic [7:0] rs,
                            input bit early, input bit stall);
        int n, m, k, guard;
        bit phase;
        bit stall_ok;
        logic prev_si;
        logic [STATE_W-1:0] got;
        settle_cycles = st;
        restart_state = rs;
        shift_ready   = 1'b1;
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
        chk((&cp_sel) && !standby && busy, "R2", outs(), 0);
        if (early) wake_req = 1'b1;
        @(negedge clk); wake_req = 1'b0;
        chk(standby && (&cp_sel) && busy, "R2", outs(), 0);
        n = 1; guard = 0;
        @(negedge clk);
        while (standby && busy && guard < 1000) begin
            n++; guard++;
            @(negedge clk);
        end
        if (early) begin
            chk(n == st + 1, "R7", n, st + 1);
            chk(!standby && busy && (&cp_sel), "R7", outs(), 0);
        end else begin
            chk(n == st + 1, "R3", n, st + 1);
            chk(standby && !busy && !ready, "R9", outs(), 0);
            sleep_req = 1'b1;
            @(negedge clk); sleep_req = 1'b0;
            repeat (3) @(negedge clk);
            chk(standby && !busy && (&cp_sel), "R8", outs(), 0);
            wake_req = 1'b1;
            @(negedge clk); wake_req = 1'b0;
            chk(!standby && (&cp_sel) && busy && !scan_en, "R4", outs(), 0);
        end
        m = 1; guard = 0;
        @(negedge clk);
        while (!shift_valid && busy && guard < 1000) begin
            m++; guard++;
            @(negedge clk);
        end
        chk(m == st + 1, "R3", m, st + 1);
        chk(shift_valid && scan_en && !standby, "R4", outs(), 0);
        k = 0; guard = 0; phase = 1'b0; stall_ok = 1'b1; got = '0; prev_si = scan_si;
        while (k < STATE_W && guard < 1000) begin
            guard++;
            if (!shift_valid) stall_ok = 1'b0;
            if (guard > 1 && !shift_ready && scan_si !== prev_si) stall_ok = 1'b0;
            shift_ready = stall ? phase : 1'b1;
            phase = ~phase;
            prev_si = scan_si;
            if (shift_ready) begin
                got[k] = scan_si;
                k++;
            end
            @(negedge clk);
        end
        chk(got == rs, "R5", got, rs);
        chk(stall_ok, "R5", stall_ok, 1);
        chk(outs() == RESET_OUTS, "R6", outs(), RESET_OUTS);
        shift_ready = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(outs() == RESET_OUTS, "R1", outs(), RESET_OUTS);
        rst_n = 1'b1;
        @(negedge clk);
        chk(outs() == RESET_OUTS, "R1", outs(), RESET_OUTS);
        // wake in normal operation is ignored
        wake_req = 1'b1;
        @(negedge clk); wake_req = 1'b0;
        repeat (2) @(negedge clk);
        chk(ready && !busy && cp_sel == '0, "R8", outs(), RESET_OUTS);
        for (int i = 0; i < NVEC; i++) begin
            scenario(VEC[i][17:10], VEC[i][9:2], VEC[i][1], VEC[i][0]);
            repeat (2) @(negedge clk);
        end
        // reset while resting in standby returns to reset state
        settle_cycles = 8'd1;
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
        repeat (6) @(negedge clk);
        chk(standby && !busy, "R3", outs(), 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk(outs() == RESET_OUTS, "R1", outs(), RESET_OUTS);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(ready && !standby, "R9", outs(), RESET_OUTS);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule